// File: doc/BRIEF.md
# Host Transmit Word Byte Packer

This block sits between a host register port and a byte-wide transmit queue. The host programs a packet-size register and then a setup register. The setup register selects the byte order and holds a leading-byte skip, a trailing-byte skip and a countdown of data writes. The host then writes 32-bit words to a write-only data register. Each accepted word is masked and sent out, one byte per handshake, on a valid/ready stream. The last kept byte of the final word carries a last flag.

The leading skip only acts on a write while the countdown is non-zero. It clears itself after that one use. The trailing skip acts on every write made while the countdown is zero. It stays in force until the host rewrites the setup register. If the packet-size register holds 1, 2 or 3, that value is the number of bytes kept on such a write, and it replaces the trailing field.

A data write that arrives while the previous word is still being sent is held off with a wait signal, so no data is lost.

Top module: `txw_byte_packer`

## Requirements
- R1: After reset, reading the setup register (byte offset 0x08) returns zero and `out_valid` is low.
- R2: Setup bit 24 selects the byte order. When it is 1, word bits 31:24 go out first and bits 7:0 go out last. When it is 0, bits 7:0 go out first.
- R3: Setup bits 19:18 (lead skip, 0..3) drop that many bytes from the start of the send order. This happens only on a data write where the countdown is non-zero. The field then reads back as zero.
- R4: Setup bits 17:16 (trail skip, 0..3) drop that many bytes from the end of the send order on every data write where the countdown is zero. The field keeps its value across those writes.
- R5: Setup bits 13:0 hold the countdown. Each accepted data write (offset 0x0C) lowers it by one until it reaches zero. It then holds at zero. The current value reads back in the same field.
- R6: When the packet-size register (offset 0x04) holds 1, 2 or 3, a data write with countdown zero keeps exactly that many leading bytes of the send order, and the trail skip field is not used. Any other size value has no effect on masking.
- R7: `out_last` is high only on the final kept byte of a data write accepted with countdown zero, and only while `out_valid` is high.
- R8: A data write made while bytes of an earlier word are still pending raises `reg_wait`. The write is held until it can be accepted, and its bytes then appear in order.
- R9: Reserved setup bits (31:25, 23:20, 15:14) read back as zero whatever was written to them. Reading the data register returns zero.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, held until reg_wait is low |
| reg_rd | input | 1 | Register read strobe, data returned in the same cycle |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_wait | output | 1 | Holds off a data write while a word is still being sent |
| out_data | output | 8 | Byte stream data |
| out_valid | output | 1 | Byte stream valid |
| out_ready | input | 1 | Byte stream ready |
| out_last | output | 1 | Final byte of the buffer |

## Verification
The hardest case to reach is a data write that lands while the serializer still holds bytes, together with the trail skip staying in force over several writes after the countdown has hit zero. The random phase throttles `out_ready` at random and sometimes adds extra data writes after a buffer has finished, with no new setup write. Directed sequences stall the stream completely while back-to-back words are written, then release it. A bench model masks each word from the register fields it tracks and predicts every byte and every last flag.

// File: rtl/txw_pkg.sv
package txw_pkg;
  // byte at position idx of the send order
  function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic big,
                                           input logic [1:0] idx);
    int sh;
    sh = big ? 8 * (3 - int'(idx)) : 8 * int'(idx);
    return w[sh +: 8];
  endfunction

  // index of the last kept byte for a given trailing drop
  function automatic logic [1:0] final_index(input logic [1:0] trail);
    return 2'd3 - trail;
  endfunction

  // trailing drop implied by a short size value, else the field
  function automatic logic [1:0] trail_amount(input logic [1:0] field, input logic short_sz,
                                              input logic [1:0] sz_low);
    return short_sz ? 2'(3'd4 - {1'b0, sz_low}) : field;
  endfunction
endpackage

// File: rtl/txw_setup_regs.sv
module txw_setup_regs #(
  parameter int CNT_W  = 14,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_wr,
  input  logic              size_wr,
  input  logic              data_acc,
  input  logic [31:0]       wdata,
  output logic              big_o,
  output logic [1:0]        lead_eff,
  output logic [1:0]        trail_eff,
  output logic              word_final,
  output logic [31:0]       setup_rd,
  output logic [31:0]       size_rd
);
  import txw_pkg::*;

  logic              big_q;
  logic [1:0]        lead_q, trail_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SIZE_W-1:0] size_q;
  logic              cnt_zero, short_sz;
  logic              unused_bits;

  assign unused_bits = ^{wdata[31:25], wdata[23:20], wdata[15:14]};
  assign cnt_zero    = (cnt_q == '0);
  assign short_sz    = (size_q != '0) && (size_q < SIZE_W'(4));

  assign big_o      = big_q;
  assign word_final = cnt_zero;
  assign lead_eff   = cnt_zero ? 2'd0 : lead_q;
  assign trail_eff  = cnt_zero ? trail_amount(trail_q, short_sz, size_q[1:0]) : 2'd0;

  always_comb begin
    setup_rd              = '0;
    setup_rd[24]          = big_q;
    setup_rd[19:18]       = lead_q;
    setup_rd[17:16]       = trail_q;
    setup_rd[CNT_W-1:0]   = cnt_q;
    size_rd               = '0;
    size_rd[SIZE_W-1:0]   = size_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      big_q <= 1'b0; lead_q <= '0; trail_q <= '0; cnt_q <= '0; size_q <= '0;
    end else begin
      if (size_wr) size_q <= wdata[SIZE_W-1:0];
      if (setup_wr) begin
        big_q   <= wdata[24];
        lead_q  <= wdata[19:18];
        trail_q <= wdata[17:16];
        cnt_q   <= wdata[CNT_W-1:0];
      end else if (data_acc && !cnt_zero) begin
        cnt_q  <= cnt_q - 1'b1;
        lead_q <= '0;
      end
    end
  end

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && !setup_wr && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r5_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && !setup_wr && cnt_q == '0 |=> cnt_q == '0);
  a_r3_lead_clears: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && !setup_wr && cnt_q != '0 |=> lead_q == '0);
  a_r4_trail_kept: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && !setup_wr |=> trail_q == $past(trail_q));
endmodule

// File: rtl/txw_serializer.sv
module txw_serializer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] word,
  input  logic        big,
  input  logic [1:0]  first_idx,
  input  logic [1:0]  last_idx,
  input  logic        tag_last,
  output logic        busy,
  output logic [7:0]  out_data,
  output logic        out_valid,
  output logic        out_last,
  input  logic        out_ready
);
  import txw_pkg::*;

  logic [31:0] word_q;
  logic        big_q, tag_q, busy_q;
  logic [1:0]  pos_q, end_q;
  logic        at_end, shift;

  assign at_end    = (pos_q == end_q);
  assign shift     = busy_q && out_ready;
  assign busy      = busy_q;
  assign out_valid = busy_q;
  assign out_data  = pick_byte(word_q, big_q, pos_q);
  assign out_last  = busy_q && tag_q && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0; big_q <= 1'b0; tag_q <= 1'b0; busy_q <= 1'b0;
      pos_q <= '0; end_q <= '0;
    end else if (load) begin
      word_q <= word;
      big_q  <= big;
      tag_q  <= tag_last;
      pos_q  <= first_idx;
      end_q  <= last_idx;
      busy_q <= (first_idx <= last_idx);
    end else if (shift) begin
      if (at_end) busy_q <= 1'b0;
      else        pos_q  <= pos_q + 1'b1;
    end
  end

  a_r8_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

// File: rtl/txw_byte_packer.sv
module txw_byte_packer #(
  parameter int         ADDR_W     = 8,
  parameter int         CNT_W      = 14,
  parameter int         SIZE_W     = 16,
  parameter logic [7:0] SIZE_ADDR  = 8'h04,
  parameter logic [7:0] SETUP_ADDR = 8'h08,
  parameter logic [7:0] DATA_ADDR  = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_wait,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last
);
  import txw_pkg::*;

  logic        hit_size, hit_setup, hit_data;
  logic        data_acc, busy;
  logic        big, word_final;
  logic [1:0]  lead_eff, trail_eff;
  logic [31:0] setup_rd, size_rd;

  assign hit_size  = (reg_addr == ADDR_W'(SIZE_ADDR));
  assign hit_setup = (reg_addr == ADDR_W'(SETUP_ADDR));
  assign hit_data  = (reg_addr == ADDR_W'(DATA_ADDR));
  assign data_acc  = reg_wr && hit_data && !busy;
  assign reg_wait  = reg_wr && hit_data && busy;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (hit_setup)     reg_rdata = setup_rd;
      else if (hit_size) reg_rdata = size_rd;
    end
  end

  txw_setup_regs #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .setup_wr(reg_wr && hit_setup), .size_wr(reg_wr && hit_size),
    .data_acc(data_acc), .wdata(reg_wdata),
    .big_o(big), .lead_eff(lead_eff), .trail_eff(trail_eff),
    .word_final(word_final), .setup_rd(setup_rd), .size_rd(size_rd));

  txw_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .load(data_acc), .word(reg_wdata), .big(big),
    .first_idx(lead_eff), .last_idx(final_index(trail_eff)), .tag_last(word_final),
    .busy(busy), .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_ready(out_ready));

  a_r8_wait_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wait |-> out_valid);
endmodule

// File: tb/txw_byte_packer_tb.sv
`timescale 1ns/1ps
module txw_byte_packer_tb;
  localparam logic [7:0] A_SIZE = 8'h04, A_SETUP = 8'h08, A_DATA = 8'h0C;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, out_ready = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic reg_wait, out_valid, out_last;
  logic [7:0] out_data;

  int n_chk = 0, n_bad = 0;
  logic stall = 1'b0, saw_wait = 1'b0, done = 1'b0;
  logic [8:0] exp_q[$];

  // bench model of the register state
  logic m_big = 0; logic [1:0] m_lead = 0, m_trail = 0;
  logic [13:0] m_cnt = 0; logic [15:0] m_size = 0;

  txw_byte_packer u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_wait(reg_wait),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last));

  always #10 clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] send_byte(input logic [31:0] w, input logic be, input int k);
    return be ? w[31-8*k -: 8] : w[8*k +: 8];
  endfunction

  function automatic logic [31:0] setup_word(input logic be, input logic [1:0] ld,
                                             input logic [1:0] tr, input logic [13:0] c);
    return {7'd0, be, 4'd0, ld, tr, 2'd0, c};
  endfunction

  task automatic model_data(input logic [31:0] w);
    int lo, hi;
    lo = (m_cnt != 0) ? int'(m_lead) : 0;
    hi = 3;
    if (m_cnt == 0) begin
      if (m_size >= 1 && m_size <= 3) hi = int'(m_size) - 1;
      else hi = 3 - int'(m_trail);
    end
    for (int k = lo; k <= hi; k++)
      exp_q.push_back({(m_cnt == 0) && (k == hi), send_byte(w, m_big, k)});
    if (m_cnt != 0) begin m_cnt--; m_lead = 0; end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    logic w;
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    forever begin
      #1 w = reg_wait;
      if (w) saw_wait = 1;
      @(posedge clk);
      if (!w) break;
      @(negedge clk);
    end
    if (a == A_DATA) model_data(d);
    else if (a == A_SETUP) begin
      m_big = d[24]; m_lead = d[19:18]; m_trail = d[17:16]; m_cnt = d[13:0];
    end else if (a == A_SIZE) m_size = d[15:0];
    #1 reg_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 v = reg_rdata;
    reg_rd = 0;
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_q.size() != 0 || out_valid) && t < 2000) begin @(negedge clk); t++; end
  endtask

  // consumer and stream scoreboard
  initial begin
    logic [8:0] held, e;
    logic was_stalled;
    was_stalled = 0; held = 0;
    forever begin
      @(negedge clk);
      out_ready = stall ? 1'b0 : ($urandom % 4 != 0);
      #1;
      if (was_stalled)
        check(out_valid && {out_last, out_data} == held, "R10 stall hold",
              {23'd0, out_last, out_data}, {23'd0, held});
      was_stalled = out_valid && !out_ready;
      if (was_stalled) held = {out_last, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R2 R8 unexpected byte", {23'd0, out_last, out_data}, 0);
        else begin
          e = exp_q.pop_front();
          check({out_last, out_data} == e, "R2 R3 R4 R6 R7 stream byte",
                {23'd0, out_last, out_data}, {23'd0, e});
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    bus_read(A_SETUP, v);
    check(v == 0, "R1 setup reset", v, 0);
    check(!out_valid, "R1 valid reset", {31'd0, out_valid}, 0);
    // R9 reserved bits and write-only data register
    bus_write(A_SETUP, 32'hFFFF_FFFF);
    bus_read(A_SETUP, v);
    check(v == 32'h010F_3FFF, "R9 reserved zero", v, 32'h010F_3FFF);
    bus_read(A_DATA, v);
    check(v == 0, "R9 data reads zero", v, 0);
    bus_write(A_SETUP, 0);
    // R2 big endian, full word, single write
    bus_write(A_SIZE, 16'd100);
    bus_write(A_SETUP, setup_word(1, 0, 0, 0));
    bus_write(A_DATA, 32'hA1B2C3D4);
    drain();
    // R3 lead skip self-clears; R5 countdown read back
    bus_write(A_SETUP, setup_word(0, 2, 1, 2));
    bus_write(A_DATA, 32'h11223344);
    bus_read(A_SETUP, v);
    check(v == setup_word(0, 0, 1, 1), "R3 R5 lead cleared count dec", v, setup_word(0, 0, 1, 1));
    bus_write(A_DATA, 32'h55667788);
    bus_write(A_DATA, 32'h99AABBCC);
    // R4 persistence and R5 hold at zero
    bus_write(A_DATA, 32'hDDEEFF00);
    bus_read(A_SETUP, v);
    check(v == setup_word(0, 0, 1, 0), "R4 R5 trail kept count zero", v, setup_word(0, 0, 1, 0));
    drain();
    // R6 short size overrides the trail field
    bus_write(A_SIZE, 16'd2);
    bus_write(A_SETUP, setup_word(1, 0, 3, 0));
    bus_write(A_DATA, 32'h0BADF00D);
    drain();
    bus_write(A_SIZE, 16'd100);
    // R8 stall with back-to-back words
    stall = 1; saw_wait = 0;
    bus_write(A_SETUP, setup_word(0, 0, 0, 1));
    bus_write(A_DATA, 32'hCAFEBABE);
    fork
      bus_write(A_DATA, 32'hDEADBEEF);
      begin repeat (12) @(negedge clk); stall = 0; end
    join
    check(saw_wait, "R8 wait raised", {31'd0, saw_wait}, 1);
    drain();
    // random phase
    for (int p = 0; p < 60; p++) begin
      int nw;
      logic [13:0] c;
      c = 14'($urandom % 5);
      bus_write(A_SIZE, ($urandom % 3 == 0) ? 32'($urandom % 4) : 32'(4 + $urandom % 60));
      bus_write(A_SETUP, setup_word(1'($urandom), 2'($urandom), 2'($urandom), c));
      nw = int'(c) + 1 + (($urandom % 4 == 0) ? 2 : 0);
      for (int i = 0; i < nw; i++) bus_write(A_DATA, $urandom);
      if (p % 5 == 0) begin
        bus_read(A_SETUP, v);
        check(v == setup_word(m_big, m_lead, m_trail, m_cnt), "R5 R4 random readback",
              v, setup_word(m_big, m_lead, m_trail, m_cnt));
      end
      if (p % 7 == 0) drain();
    end
    drain();
    check(exp_q.size() == 0, "R7 R8 all bytes delivered", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule